// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block divides the system clock down to a one-cycle enable pulse at sixteen times the serial bit rate. The divisor has a 16-bit whole part and a 6-bit fraction counted in 1/64 steps. The whole part sets the base length of each pulse period. A 6-bit phase accumulator adds the fraction once per period. A period whose addition overflows the accumulator is made one clock longer. The mean period is therefore whole + fraction/64 clocks.

Software writes the two divisor fields through separate write strobes, and it does so while the enable input is low. When the block starts, it copies both fields into an active set and runs from that copy. Writes made while the block runs only take effect after the next restart. When the enable is low, or the whole part is zero, the period counter and the accumulator stay at zero and no pulse is produced. For example, a 48 MHz clock with a whole part of 26 and a fraction of 3 gives roughly 115200 baud.

Top module: `frac_baud_tick`

## Requirements
- R1: During and after reset, tick_o is low, the period counter and the phase accumulator are zero, and the block is stopped.
- R2: tick_o is high for exactly one cycle at the end of each period. It is only ever high in a cycle that follows a clock edge at which enable_i was high.
- R3: Every period lasts I clocks, or I+1 clocks when adding the fraction F to the 6-bit accumulator carries out of bit 5. I is the active whole part and F is the active fraction. The accumulator starts at 0 and keeps the 6-bit sum after each period.
- R4: Over any 64 consecutive periods counted from a start, the total length is exactly 64*I + F clocks.
- R5: The block starts at the first clock edge where enable_i is high, the block is stopped, and the whole part register is nonzero. At that edge it copies both register fields, and the first period begins in the next cycle. Register writes made while the block runs do not change the period until the next start.
- R6: A whole part of 0 keeps the block stopped. No tick is produced while enable_i is high.
- R7: A clock edge with enable_i low stops the block and clears the counter and the accumulator. After re-enabling, the periods repeat the sequence from a fresh start.
- R8: With I=1 and F=0, a tick is produced in every cycle.
- R9: With I=26 and F=3, the 64th tick comes 1667 clocks after the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Run request; low stops and clears the generator |
| int_we_i | input | 1 | Write strobe for the whole part register |
| int_wdata_i | input | 16 | Whole part of the divisor |
| frac_we_i | input | 1 | Write strobe for the fraction register |
| frac_wdata_i | input | 6 | Fraction of the divisor in 1/64 units |
| tick_o | output | 1 | One-cycle 16x oversampling pulse |

## Verification
The generator is run with a fraction of 0, where every period must be exactly I clocks. It is also run with small and odd fractions such as 3 and 37, which spread the long periods unevenly, and with 63, where nearly every period is stretched. A whole part of 1 covers the shortest legal period, and a whole part of 0 must stay silent. Writes during a run must leave the period unchanged until a restart. Disabling in the middle of a period must restart the accumulator phase from zero. This tells a design that holds its phase apart from one that clears it.

// File: rtl/frac_baud_tick_pkg.sv
package frac_baud_tick_pkg;
  parameter int unsigned INT_W  = 16;
  parameter int unsigned FRAC_W = 6;
endpackage

// File: rtl/baud_div_regs.sv
module baud_div_regs #(
  parameter int unsigned INT_W  = 16,
  parameter int unsigned FRAC_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              int_we_i,
  input  logic [INT_W-1:0]  int_wdata_i,
  input  logic              frac_we_i,
  input  logic [FRAC_W-1:0] frac_wdata_i,
  input  logic              load_i,
  output logic              prog_nz_o,
  output logic [INT_W-1:0]  act_int_o,
  output logic [FRAC_W-1:0] act_frac_o
);
  logic [INT_W-1:0]  prog_int_q;
  logic [FRAC_W-1:0] prog_frac_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prog_int_q  <= '0;
      prog_frac_q <= '0;
    end else begin
      if (int_we_i)  prog_int_q  <= int_wdata_i;
      if (frac_we_i) prog_frac_q <= frac_wdata_i;
    end
  end

  // active copy is taken only at start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_int_o  <= '0;
      act_frac_o <= '0;
    end else if (load_i) begin
      act_int_o  <= prog_int_q;
      act_frac_o <= prog_frac_q;
    end
  end

  assign prog_nz_o = |prog_int_q;
endmodule

// File: rtl/baud_phase_acc.sv
module baud_phase_acc #(
  parameter int unsigned FRAC_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              adv_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic [FRAC_W-1:0] acc_o,
  output logic              carry_o
);
  logic [FRAC_W:0] sum;

  assign sum     = {1'b0, acc_o} + {1'b0, frac_i};
  assign carry_o = sum[FRAC_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_o <= '0;
    else if (clr_i) acc_o <= '0;
    else if (adv_i) acc_o <= sum[FRAC_W-1:0];
  end
endmodule

// File: rtl/baud_period_cnt.sv
module baud_period_cnt #(
  parameter int unsigned CNT_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] last_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  assign wrap_o = run_i && (cnt_o == last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (wrap_o) cnt_o <= '0;
    else if (run_i)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/frac_baud_tick.sv
module frac_baud_tick
  import frac_baud_tick_pkg::*;
#(
  parameter int unsigned INT_WIDTH  = INT_W,
  parameter int unsigned FRAC_WIDTH = FRAC_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  enable_i,
  input  logic                  int_we_i,
  input  logic [INT_WIDTH-1:0]  int_wdata_i,
  input  logic                  frac_we_i,
  input  logic [FRAC_WIDTH-1:0] frac_wdata_i,
  output logic                  tick_o
);
  localparam int unsigned CNT_W = INT_WIDTH + 1;

  logic                  running_q;
  logic                  prog_nz;
  logic                  start;
  logic                  clr;
  logic                  carry;
  logic                  wrap;
  logic [INT_WIDTH-1:0]  act_int;
  logic [FRAC_WIDTH-1:0] act_frac;
  logic [FRAC_WIDTH-1:0] acc;
  logic [CNT_W-1:0]      cnt;
  logic [CNT_W-1:0]      last;

  assign start = enable_i && !running_q && prog_nz;
  assign clr   = !enable_i || !running_q;
  // act_int is nonzero whenever running, so no underflow
  assign last  = {1'b0, act_int} + {{(CNT_W-1){1'b0}}, carry} - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) running_q <= 1'b0;
    else         running_q <= enable_i && (running_q || prog_nz);
  end

  baud_div_regs #(.INT_W(INT_WIDTH), .FRAC_W(FRAC_WIDTH)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .int_we_i    (int_we_i),
    .int_wdata_i (int_wdata_i),
    .frac_we_i   (frac_we_i),
    .frac_wdata_i(frac_wdata_i),
    .load_i      (start),
    .prog_nz_o   (prog_nz),
    .act_int_o   (act_int),
    .act_frac_o  (act_frac)
  );

  baud_phase_acc #(.FRAC_W(FRAC_WIDTH)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .adv_i  (wrap),
    .frac_i (act_frac),
    .acc_o  (acc),
    .carry_o(carry)
  );

  baud_period_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .run_i (running_q),
    .last_i(last),
    .cnt_o (cnt),
    .wrap_o(wrap)
  );

  assign tick_o = wrap;
endmodule

// File: rtl/frac_baud_tick_chk.sv
module frac_baud_tick_chk #(
  parameter int unsigned INT_WIDTH  = 16,
  parameter int unsigned FRAC_WIDTH = 6
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  enable_i,
  input logic                  tick_o,
  input logic                  running_q,
  input logic [INT_WIDTH:0]    cnt,
  input logic [FRAC_WIDTH-1:0] acc,
  input logic [INT_WIDTH-1:0]  act_int,
  input logic                  carry
);
  a_r2_tick_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> $past(enable_i));

  a_r1_idle_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running_q |-> (cnt == '0 && acc == '0 && !tick_o));

  a_r3_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running_q |-> ({1'b0, cnt} < ({2'b0, act_int} + {{(INT_WIDTH+1){1'b0}}, carry})));

  a_r3_restart_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (cnt == '0));

  a_r5_divisor_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_q && $past(running_q)) |-> $stable(act_int));

  a_r6_nonzero_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running_q |-> (act_int != '0));

  a_r7_stop_on_disable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(enable_i) |-> !running_q);
endmodule

bind frac_baud_tick frac_baud_tick_chk #(.INT_WIDTH(INT_WIDTH), .FRAC_WIDTH(FRAC_WIDTH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .enable_i (enable_i),
  .tick_o   (tick_o),
  .running_q(running_q),
  .cnt      (cnt),
  .acc      (acc),
  .act_int  (act_int),
  .carry    (carry)
);

// File: tb/frac_baud_tick_tb.sv
module frac_baud_tick_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        enable_i = 1'b0;
  logic        int_we_i = 1'b0;
  logic [15:0] int_wdata_i = '0;
  logic        frac_we_i = 1'b0;
  logic [5:0]  frac_wdata_i = '0;
  logic        tick_o;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  // behavioural model
  int m_int = 0, m_frac = 0, a_int = 0, a_frac = 0;
  bit m_run = 0;
  int c = 0, n = 0;
  int cycles = 0;

  always #4 clk_i = ~clk_i;

  frac_baud_tick u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i),
    .int_we_i(int_we_i), .int_wdata_i(int_wdata_i),
    .frac_we_i(frac_we_i), .frac_wdata_i(frac_wdata_i),
    .tick_o(tick_o)
  );

  function automatic bit exp_tick();
    return m_run && (c == n * a_int + (n * a_frac) / 64);
  endfunction

  task automatic check(input bit act, input bit exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: tick_o=%0b expected %0b (cycle %0d)", req, act, exp, cycles);
    end
  endtask

  task automatic cyc();
    bit e;
    @(posedge clk_i);
    cycles++;
    e = exp_tick();
    if (!enable_i) m_run = 0;
    else if (m_run) begin
      if (e) n++;
      c++;
    end else if (m_int != 0) begin
      m_run = 1; a_int = m_int; a_frac = m_frac; c = 1; n = 1;
    end
    if (int_we_i)  m_int  = int_wdata_i;
    if (frac_we_i) m_frac = frac_wdata_i;
    @(negedge clk_i);
    int_we_i  = 1'b0;
    frac_we_i = 1'b0;
    check(tick_o, exp_tick(), tag);
  endtask

  task automatic run(input int k);
    for (int i = 0; i < k; i++) cyc();
  endtask

  task automatic wr(input int iv, input int fv);
    int_we_i = 1'b1; int_wdata_i = 16'(iv);
    frac_we_i = 1'b1; frac_wdata_i = 6'(fv);
    cyc();
  endtask

  task automatic restart(input int iv, input int fv);
    enable_i = 1'b0;
    cyc();
    wr(iv, fv);
    enable_i = 1'b1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int k, seen, gap, prev;
    // R1: reset state
    repeat (3) @(negedge clk_i);
    check(tick_o, 1'b0, "R1");
    rst_ni = 1'b1;
    run(4);

    // R9 / R4: 26 + 3/64, 64 ticks after 1667 clocks
    tag = "R9";
    wr(26, 3);
    enable_i = 1'b1;
    cyc();
    k = 1; seen = 0;
    while (1) begin
      if (tick_o) seen++;
      if (seen == 64) break;
      cyc(); k++;
    end
    checks++;
    if (k != 1667) begin
      errors++;
      $display("FAIL R9/R4: 64th tick at %0d expected 1667", k);
    end

    // R3 / R4: uneven fraction, measure every gap
    tag = "R3";
    restart(5, 37);
    cyc();
    seen = 0; prev = 0; k = 1; gap = 0;
    while (seen < 64) begin
      if (tick_o) begin
        seen++;
        checks++;
        if ((k - prev) != 5 && (k - prev) != 6) begin
          errors++;
          $display("FAIL R3: period %0d expected 5 or 6", k - prev);
        end
        prev = k;
      end
      if (seen < 64) begin cyc(); k++; end
    end
    checks++;
    if (k != 64 * 5 + 37) begin
      errors++;
      $display("FAIL R4: 64 periods took %0d expected %0d", k, 64 * 5 + 37);
    end

    // R3: fraction near maximum, zero fraction
    restart(2, 63);
    run(300);
    restart(7, 0);
    run(200);

    // R8: shortest period
    tag = "R8";
    restart(1, 0);
    cyc();
    for (int i = 0; i < 20; i++) begin
      checks++;
      if (tick_o !== 1'b1) begin
        errors++;
        $display("FAIL R8: tick_o=%0b expected 1", tick_o);
      end
      cyc();
    end
    restart(1, 63);
    run(150);

    // R5: writes during run have no effect until restart
    tag = "R5";
    restart(3, 0);
    run(10);
    wr(10, 5);
    run(60);
    enable_i = 1'b0;
    cyc();
    enable_i = 1'b1;
    run(200);

    // R7: disable mid-period, restart fresh
    tag = "R7";
    restart(4, 45);
    run(13);
    enable_i = 1'b0;
    cyc();
    for (int i = 0; i < 5; i++) begin
      cyc();
      checks++;
      if (tick_o !== 1'b0) begin
        errors++;
        $display("FAIL R7: tick_o=%0b expected 0 while disabled", tick_o);
      end
    end
    enable_i = 1'b1;
    run(200);

    // R6: zero whole part stays silent
    tag = "R6";
    restart(0, 17);
    seen = 0;
    for (int i = 0; i < 100; i++) begin
      cyc();
      if (tick_o) seen++;
    end
    checks++;
    if (seen != 0) begin
      errors++;
      $display("FAIL R6: %0d ticks expected 0", seen);
    end

    // R2: pulses are single-cycle, back to nominal divisor
    tag = "R2";
    restart(9, 11);
    prev = 0;
    for (int i = 0; i < 200; i++) begin
      cyc();
      if (prev == 1 && tick_o) begin
        errors++;
        $display("FAIL R2: tick_o=1 on consecutive cycles expected 0");
      end
      prev = tick_o;
    end
    checks++;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule